// File: doc/BRIEF.md
# TPM-over-SPI Transaction Flow Controller

This block is the device side of TPM-over-SPI transactions, with the SPI shifting modelled at byte level. Each byte slot is marked by a one-cycle strobe that carries the byte from the host. The block shows on `tx_byte` the byte it returns in the current slot. It decodes a four-byte header of one command byte and a 24-bit address. A small set of registers is served directly from inputs that software maintains. Every other transaction is handed to software: the command and address go into a command/address FIFO as one 32-bit word.

After the header the block sends wait-state bytes. A read waits until software has filled the read FIFO with the whole payload. A write waits until software has drained the write FIFO. The block then sends a start byte and moves the payload. A mode input switches from FIFO interface behaviour, where hardware registers answer at once, to CRB behaviour, where software answers everything. Locality inputs decide whether the status register is returned by hardware.

Top module: `tpm_spi_flow`

## Requirements
- R1: While `en` is low the block ignores all slots. `tx_byte` stays 0xFF, nothing enters the command FIFO and nothing enters the write FIFO.
- R2: The header is one command byte followed by three address bytes, most significant first. In the command byte, bit 7 set means a read and bits 5:0 hold the transfer size minus one. In the address, bits 15:12 select the locality and bits 11:0 give the register offset.
- R3: Wait-state bytes use 0x00 for WAIT and 0x01 for START. The byte returned during the last address byte is always WAIT. A WAIT is repeated in each following slot until the block is ready. The slot after START carries the first payload byte.
- R4: In FIFO mode, with the hardware-register-disable input low, a read that hits the hardware set completes with exactly one wait state and is not uploaded. The hardware set has three entries:
  - offset 0x000 returns the locality's access byte in byte lane 0 and zero in the other lanes;
  - offsets 0x018-0x01B return the status word;
  - offsets 0xF00-0xF03 return the identity word.
  Payload byte i comes from lane (offset[1:0]+i) mod 4, where lane n is bits 8n+7:8n.
- R5: In CRB mode, or with the hardware-register-disable input set, every read is uploaded to software. The uploaded word holds the command byte in bits 31:24 and the address in bits 23:0.
- R6: A software-serviced read returns WAIT until the read FIFO holds at least the transfer size in bytes. It then returns START, followed by the FIFO bytes in push order.
- R7: A write is always uploaded. It returns WAIT while the write FIFO is not empty, then START. The payload bytes enter the write FIFO in order.
- R8: The status register is answered by hardware only for the active locality, which is the one whose access byte has bit 5 set. For any other locality, with `inv_loc_en` set, hardware answers 0xFF bytes; with it clear, the read is uploaded. A locality number of `NUM_LOC` or above is treated the same way for every hardware register.
- R9: `cmd_not_empty` is a level signal. It stays high until software has popped every queued command word.
- R10: `cs_n` high aborts any transaction, forces `tx_byte` to 0xFF and makes the next slot a header byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| crb_mode | input | 1 | 1 = CRB interface behaviour, 0 = FIFO interface behaviour |
| hw_reg_dis | input | 1 | Sends all reads to software |
| inv_loc_en | input | 1 | Hardware answers 0xFF for reads from an invalid or inactive locality |
| access_regs | input | 8*NUM_LOC | Access byte per locality, locality 0 in the low byte |
| sts_reg | input | 32 | Status word |
| id_reg | input | 32 | Identity word |
| cs_n | input | 1 | Chip select, active low |
| byte_stb | input | 1 | One-cycle marker of a completed byte slot |
| rx_byte | input | 8 | Byte received from the host in this slot |
| tx_byte | output | 8 | Byte returned to the host in the current slot |
| cmd_pop | input | 1 | Software pop of the command FIFO |
| cmd_data | output | 32 | Head command word |
| cmd_not_empty | output | 1 | Level interrupt: command word pending |
| rdf_push | input | 1 | Software push into the read FIFO |
| rdf_data | input | 8 | Read FIFO push data |
| rdf_full | output | 1 | Read FIFO full |
| wrf_pop | input | 1 | Software pop of the write FIFO |
| wrf_data | output | 8 | Head write FIFO byte |
| wrf_empty | output | 1 | Write FIFO empty |

## Verification
On the edge that takes in the last address byte, the command upload and the WAIT/START decision happen together. A write issued while the write FIFO is empty provokes both at once. The bench judges it by finding the exact command word in the FIFO and START in the very next slot. A second overlap comes when software pops the write FIFO while the host is polling wait states. The bench drains the FIFO between polls and requires WAIT until the drain completes, then START, with no payload byte lost or reordered.

// File: rtl/tpm_flow_pkg.sv
package tpm_flow_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ADDR = 3'd1,
    S_WAIT = 3'd2,
    S_DATA = 3'd3,
    S_DONE = 3'd4
  } tpm_state_e;

  localparam logic [7:0] BYTE_WAIT  = 8'h00;
  localparam logic [7:0] BYTE_START = 8'h01;
  localparam logic [7:0] BYTE_IDLE  = 8'hFF;

  // word indexes (offset[11:2]) of the hardware-returned registers
  localparam logic [9:0] W_ACCESS = 10'h000;
  localparam logic [9:0] W_STATUS = 10'h006;
  localparam logic [9:0] W_IDENT  = 10'h3C0;

  localparam int unsigned ACTIVE_BIT = 5;

endpackage

// File: rtl/tpm_fifo.sv
module tpm_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty,
  output logic                       full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rd_q];
  assign count   = cnt_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_ok) wr_d = (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + AW'(1);
    if (pop_ok)  rd_d = (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + AW'(1);
    if (push_ok && !pop_ok)      cnt_d = cnt_q + CW'(1);
    else if (pop_ok && !push_ok) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= wdata;
  end

endmodule

// File: rtl/tpm_hw_regs.sv
module tpm_hw_regs
  import tpm_flow_pkg::*;
#(
  parameter int unsigned NUM_LOC = 5
) (
  input  logic [8*NUM_LOC-1:0] access_regs,
  input  logic [31:0]          sts_reg,
  input  logic [31:0]          id_reg,
  input  logic                 inv_loc_en,
  input  logic [15:0]          addr,
  input  logic [1:0]           idx,
  output logic                 hw_ok,
  output logic [7:0]           hw_byte
);
  logic [3:0] loc;
  logic [9:0] word;
  logic [1:0] lane;
  logic [7:0] acc_sel;
  logic       loc_valid, loc_active;

  assign loc        = addr[15:12];
  assign word       = addr[11:2];
  assign lane       = addr[1:0] + idx;
  assign loc_valid  = (32'(loc) < NUM_LOC);
  assign loc_active = loc_valid && acc_sel[ACTIVE_BIT];

  always_comb begin
    acc_sel = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (32'(loc) == i) acc_sel = access_regs[8*i +: 8];
    end
  end

  always_comb begin
    hw_ok   = 1'b0;
    hw_byte = BYTE_IDLE;
    if (word == W_ACCESS) begin
      if (loc_valid) begin
        hw_ok   = 1'b1;
        hw_byte = (lane == 2'd0) ? acc_sel : 8'h00;
      end else if (inv_loc_en) begin
        hw_ok = 1'b1;
      end
    end else if (word == W_STATUS) begin
      if (loc_active) begin
        hw_ok   = 1'b1;
        hw_byte = sts_reg[{lane, 3'b000} +: 8];
      end else if (inv_loc_en) begin
        hw_ok = 1'b1;
      end
    end else if (word == W_IDENT) begin
      if (loc_valid) begin
        hw_ok   = 1'b1;
        hw_byte = id_reg[{lane, 3'b000} +: 8];
      end else if (inv_loc_en) begin
        hw_ok = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tpm_spi_flow.sv
module tpm_spi_flow
  import tpm_flow_pkg::*;
#(
  parameter int unsigned NUM_LOC   = 5,
  parameter int unsigned CMD_DEPTH = 4,
  parameter int unsigned RD_DEPTH  = 64,
  parameter int unsigned WR_DEPTH  = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 crb_mode,
  input  logic                 hw_reg_dis,
  input  logic                 inv_loc_en,
  input  logic [8*NUM_LOC-1:0] access_regs,
  input  logic [31:0]          sts_reg,
  input  logic [31:0]          id_reg,
  input  logic                 cs_n,
  input  logic                 byte_stb,
  input  logic [7:0]           rx_byte,
  output logic [7:0]           tx_byte,
  input  logic                 cmd_pop,
  output logic [31:0]          cmd_data,
  output logic                 cmd_not_empty,
  input  logic                 rdf_push,
  input  logic [7:0]           rdf_data,
  output logic                 rdf_full,
  input  logic                 wrf_pop,
  output logic [7:0]           wrf_data,
  output logic                 wrf_empty
);
  localparam int unsigned CMD_CW = $clog2(CMD_DEPTH+1);
  localparam int unsigned RD_CW  = $clog2(RD_DEPTH+1);
  localparam int unsigned WR_CW  = $clog2(WR_DEPTH+1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  tpm_state_e  state_q, state_d;
  logic [7:0]  hdr_q, hdr_d;
  logic [23:0] addr_q, addr_d;
  logic [1:0]  acnt_q, acnt_d;
  logic [6:0]  scnt_q, scnt_d;
  logic        hw_q, hw_d;
  logic [7:0]  tx_q, tx_d;

  logic        cmd_push, cmd_full, cmd_empty;
  logic [31:0] cmd_wdata;
  logic [CMD_CW-1:0] cmd_count;
  logic        rdf_pop, rdf_empty;
  logic [7:0]  rdf_rdata;
  logic [RD_CW-1:0] rdf_count;
  logic        wrf_push, wrf_full;
  logic [WR_CW-1:0] wrf_count;

  logic [15:0] dec_addr;
  logic [6:0]  size, scnt_inc;
  logic [1:0]  dec_idx;
  logic        hw_ok, sw_ready, is_rd;
  logic [7:0]  hw_byte;

  assign is_rd    = hdr_q[7];
  assign size     = {1'b0, hdr_q[5:0]} + 7'd1;
  assign scnt_inc = scnt_q + 7'd1;
  assign dec_addr = (state_q == S_ADDR) ? {addr_q[7:0], rx_byte} : addr_q[15:0];
  assign dec_idx  = (state_q == S_DATA) ? scnt_inc[1:0] : 2'd0;
  assign sw_ready = is_rd ? (32'(rdf_count) >= 32'(size)) : wrf_empty;

  tpm_hw_regs #(.NUM_LOC(NUM_LOC)) u_hw_regs (
    .access_regs (access_regs),
    .sts_reg     (sts_reg),
    .id_reg      (id_reg),
    .inv_loc_en  (inv_loc_en),
    .addr        (dec_addr),
    .idx         (dec_idx),
    .hw_ok       (hw_ok),
    .hw_byte     (hw_byte)
  );

  always_comb begin
    state_d   = state_q;
    hdr_d     = hdr_q;
    addr_d    = addr_q;
    acnt_d    = acnt_q;
    scnt_d    = scnt_q;
    hw_d      = hw_q;
    tx_d      = tx_q;
    cmd_push  = 1'b0;
    cmd_wdata = {hdr_q, addr_q[15:0], rx_byte};
    rdf_pop   = 1'b0;
    wrf_push  = 1'b0;
    if (!en || cs_n) begin
      state_d = S_IDLE;
      tx_d    = BYTE_IDLE;
    end else if (byte_stb) begin
      unique case (state_q)
        S_IDLE: begin
          hdr_d   = rx_byte;
          acnt_d  = 2'd0;
          state_d = S_ADDR;
          tx_d    = BYTE_WAIT;
        end
        S_ADDR: begin
          addr_d = {addr_q[15:0], rx_byte};
          acnt_d = acnt_q + 2'd1;
          if (acnt_q == 2'd2) begin
            hw_d     = is_rd && !crb_mode && !hw_reg_dis && hw_ok;
            cmd_push = !hw_d;
            state_d  = S_WAIT;
            tx_d     = (hw_d || sw_ready) ? BYTE_START : BYTE_WAIT;
          end else begin
            tx_d = BYTE_WAIT;
          end
        end
        S_WAIT: begin
          if (tx_q == BYTE_START) begin
            state_d = S_DATA;
            scnt_d  = 7'd0;
            if (is_rd) begin
              tx_d    = hw_q ? hw_byte : rdf_rdata;
              rdf_pop = !hw_q;
            end else begin
              tx_d = BYTE_WAIT;
            end
          end else begin
            tx_d = (hw_q || sw_ready) ? BYTE_START : BYTE_WAIT;
          end
        end
        S_DATA: begin
          scnt_d   = scnt_inc;
          wrf_push = !is_rd;
          if (scnt_inc == size) begin
            state_d = S_DONE;
            tx_d    = BYTE_IDLE;
          end else if (is_rd) begin
            tx_d    = hw_q ? hw_byte : rdf_rdata;
            rdf_pop = !hw_q;
          end
        end
        default: tx_d = BYTE_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= S_IDLE;
      hdr_q   <= '0;
      addr_q  <= '0;
      acnt_q  <= '0;
      scnt_q  <= '0;
      hw_q    <= 1'b0;
      tx_q    <= BYTE_IDLE;
    end else begin
      state_q <= state_d;
      hdr_q   <= hdr_d;
      addr_q  <= addr_d;
      acnt_q  <= acnt_d;
      scnt_q  <= scnt_d;
      hw_q    <= hw_d;
      tx_q    <= tx_d;
    end
  end

  assign tx_byte = tx_q;

  tpm_fifo #(.W(32), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
    .clk (clk), .rst_n (rst_ns),
    .push (cmd_push), .wdata (cmd_wdata),
    .pop (cmd_pop), .rdata (cmd_data),
    .count (cmd_count), .empty (cmd_empty), .full (cmd_full)
  );
  assign cmd_not_empty = !cmd_empty;

  tpm_fifo #(.W(8), .DEPTH(RD_DEPTH)) u_rd_fifo (
    .clk (clk), .rst_n (rst_ns),
    .push (rdf_push), .wdata (rdf_data),
    .pop (rdf_pop), .rdata (rdf_rdata),
    .count (rdf_count), .empty (rdf_empty), .full (rdf_full)
  );

  tpm_fifo #(.W(8), .DEPTH(WR_DEPTH)) u_wr_fifo (
    .clk (clk), .rst_n (rst_ns),
    .push (wrf_push), .wdata (rx_byte),
    .pop (wrf_pop), .rdata (wrf_data),
    .count (wrf_count), .empty (wrf_empty), .full (wrf_full)
  );

endmodule

// File: rtl/tpm_spi_flow_chk.sv
module tpm_spi_flow_chk (
  input logic       clk,
  input logic       rst_ns,
  input logic       en,
  input logic       cs_n,
  input logic       byte_stb,
  input logic [7:0] tx_byte,
  input logic       cmd_push,
  input logic       cmd_full,
  input logic       cmd_pop,
  input logic       cmd_not_empty,
  input logic       rdf_pop,
  input logic       rdf_empty,
  input logic       wrf_push,
  input logic       wrf_full
);

  assert_disabled_idle_R1: assert property (@(posedge clk) disable iff (!rst_ns)
    !en |=> tx_byte == 8'hFF);

  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    (!cs_n && en && $past(!cs_n && en && !byte_stb)) |-> $stable(tx_byte));

  assert_rd_underflow_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    rdf_pop |-> !rdf_empty);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    wrf_push |-> !wrf_full);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    cmd_push |-> !cmd_full);

  assert_level_irq_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (cmd_not_empty && !cmd_pop) |=> cmd_not_empty);

  assert_cs_idle_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    cs_n |=> tx_byte == 8'hFF);

endmodule

bind tpm_spi_flow tpm_spi_flow_chk u_chk (
  .clk           (clk),
  .rst_ns        (rst_ns),
  .en            (en),
  .cs_n          (cs_n),
  .byte_stb      (byte_stb),
  .tx_byte       (tx_byte),
  .cmd_push      (cmd_push),
  .cmd_full      (cmd_full),
  .cmd_pop       (cmd_pop),
  .cmd_not_empty (cmd_not_empty),
  .rdf_pop       (rdf_pop),
  .rdf_empty     (rdf_empty),
  .wrf_push      (wrf_push),
  .wrf_full      (wrf_full)
);

// File: tb/tpm_spi_flow_bench.sv
module tpm_spi_flow_bench;
  localparam int NUM_LOC = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, en, crb_mode, hw_reg_dis, inv_loc_en;
  logic [8*NUM_LOC-1:0] access_regs;
  logic [31:0] sts_reg, id_reg;
  logic cs_n, byte_stb;
  logic [7:0] rx_byte, tx_byte;
  logic cmd_pop, cmd_not_empty;
  logic [31:0] cmd_data;
  logic rdf_push, rdf_full;
  logic [7:0] rdf_data;
  logic wrf_pop, wrf_empty;
  logic [7:0] wrf_data;

  int checks = 0;
  int errors = 0;

  tpm_spi_flow #(.NUM_LOC(NUM_LOC)) u_tpm_spi_flow (
    .clk (clk), .rst_n (rst_n), .en (en), .crb_mode (crb_mode),
    .hw_reg_dis (hw_reg_dis), .inv_loc_en (inv_loc_en),
    .access_regs (access_regs), .sts_reg (sts_reg), .id_reg (id_reg),
    .cs_n (cs_n), .byte_stb (byte_stb), .rx_byte (rx_byte), .tx_byte (tx_byte),
    .cmd_pop (cmd_pop), .cmd_data (cmd_data), .cmd_not_empty (cmd_not_empty),
    .rdf_push (rdf_push), .rdf_data (rdf_data), .rdf_full (rdf_full),
    .wrf_pop (wrf_pop), .wrf_data (wrf_data), .wrf_empty (wrf_empty)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  task automatic slot(input logic [7:0] mosi, output logic [7:0] miso);
    @(negedge clk);
    miso     = tx_byte;
    rx_byte  = mosi;
    byte_stb = 1'b1;
    @(negedge clk);
    byte_stb = 1'b0;
  endtask

  task automatic cs_begin();
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  task automatic cs_end();
    @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // sends command + address; returns the byte seen during the last address byte
  task automatic header(input bit rd, input int size, input logic [23:0] addr,
                        output logic [7:0] last);
    logic [7:0] m;
    slot({rd, 1'b0, 6'(size - 1)}, m);
    slot(addr[23:16], m);
    slot(addr[15:8], m);
    slot(addr[7:0], last);
  endtask

  // polls until START; waits = WAIT bytes seen before it
  task automatic poll(input int limit, output int waits);
    logic [7:0] m;
    waits = 0;
    for (int i = 0; i < limit; i++) begin
      slot(8'h00, m);
      if (m == 8'h01) return;
      waits++;
    end
  endtask

  function automatic logic [7:0] lane_of(input logic [31:0] v, input logic [1:0] ofs, input int i);
    logic [1:0] l;
    l = ofs + 2'(i);
    return v[8*l +: 8];
  endfunction

  task automatic hw_read(input string req, input logic [23:0] addr, input int size,
                         input logic [31:0] val);
    logic [7:0] last, m;
    int waits;
    cs_begin();
    header(1'b1, size, addr, last);
    check({req, " wait during last address byte"}, {24'h0, last}, 32'h00);
    poll(4, waits);
    check({req, " single wait state"}, waits, 0);
    for (int i = 0; i < size; i++) begin
      slot(8'h00, m);
      check({req, " hw data"}, {24'h0, m}, {24'h0, lane_of(val, addr[1:0], i)});
    end
    cs_end();
    check({req, " no upload"}, {31'h0, cmd_not_empty}, 0);
  endtask

  task automatic rdf_load(input logic [7:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rdf_push = 1'b1;
      rdf_data = base + 8'(i);
    end
    @(negedge clk);
    rdf_push = 1'b0;
  endtask

  task automatic cmd_take(input string req, input logic [31:0] exp);
    @(negedge clk);
    check({req, " cmd pending"}, {31'h0, cmd_not_empty}, 1);
    check({req, " cmd word"}, cmd_data, exp);
    cmd_pop = 1'b1;
    @(negedge clk);
    cmd_pop = 1'b0;
  endtask

  // software-serviced read: WAIT until the read FIFO is loaded, then data
  task automatic sw_read(input string req, input logic [23:0] addr, input int size,
                         input logic [7:0] base);
    logic [7:0] last, m;
    int waits;
    cs_begin();
    header(1'b1, size, addr, last);
    check({req, " wait on last address byte"}, {24'h0, last}, 32'h00);
    poll(3, waits);
    check({req, " WAIT while read FIFO empty"}, waits, 3);
    rdf_load(base, size);
    poll(4, waits);
    check({req, " START after load"}, {31'h0, waits < 4}, 1);
    for (int i = 0; i < size; i++) begin
      slot(8'h00, m);
      check({req, " sw data order"}, {24'h0, m}, {24'h0, base + 8'(i)});
    end
    cs_end();
    cmd_take(req, {1'b1, 1'b0, 6'(size - 1), addr});
  endtask

  task automatic t_reset();
    check("R10 reset tx idle", {24'h0, tx_byte}, 32'hFF);
    check("R9 reset no cmd", {31'h0, cmd_not_empty}, 0);
    check("R7 reset write FIFO empty", {31'h0, wrf_empty}, 1);
  endtask

  task automatic t_hw_regs();
    hw_read("R4 R2 status loc0", 24'hD40018, 4, sts_reg);
    hw_read("R4 identity upper lanes", 24'hD40F02, 2, id_reg);
    hw_read("R4 access byte", 24'hD40000, 2, {24'h0, access_regs[7:0]});
  endtask

  task automatic t_locality();
    inv_loc_en = 1'b1;
    hw_read("R8 inactive locality 0xFF", 24'hD41018, 2, 32'hFFFFFFFF);
    hw_read("R8 out-of-range locality", 24'hD47F00, 1, 32'hFFFFFFFF);
    inv_loc_en = 1'b0;
    sw_read("R8 inactive locality upload", 24'hD41018, 4, 8'h50);
  endtask

  task automatic t_sw_modes();
    crb_mode = 1'b1;
    sw_read("R5 R6 CRB status", 24'hD40018, 3, 8'h60);
    crb_mode   = 1'b0;
    hw_reg_dis = 1'b1;
    sw_read("R5 hw disable", 24'hD40F00, 2, 8'h70);
    hw_reg_dis = 1'b0;
  endtask

  task automatic t_writes();
    logic [7:0] last, m;
    int waits;
    cs_begin();
    header(1'b0, 3, 24'hD40024, last);
    check("R7 wait on last address byte", {24'h0, last}, 32'h00);
    poll(4, waits);
    check("R7 START with write FIFO empty", waits, 0);
    slot(8'hAA, m); slot(8'hBB, m); slot(8'hCC, m);
    cs_end();
    cs_begin();
    header(1'b0, 2, 24'hD40028, last);
    poll(3, waits);
    check("R7 WAIT while write FIFO holds data", waits, 3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7 write payload order", {24'h0, wrf_data}, {24'h0, 8'hAA + 8'(17 * i)});
      wrf_pop = 1'b1;
      @(negedge clk);
      wrf_pop = 1'b0;
    end
    poll(4, waits);
    check("R7 START after drain", {31'h0, waits < 4}, 1);
    slot(8'h11, m); slot(8'h22, m);
    cs_end();
    check("R9 level with two words", {31'h0, cmd_not_empty}, 1);
    cmd_take("R7 first write", 32'h02D40024);
    check("R9 still pending after one pop", {31'h0, cmd_not_empty}, 1);
    cmd_take("R7 second write", 32'h01D40028);
    check("R9 cleared after drain", {31'h0, cmd_not_empty}, 0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check("R7 second payload", {24'h0, wrf_data}, {24'h0, 8'h11 * 8'(i + 1)});
      wrf_pop = 1'b1;
      @(negedge clk);
      wrf_pop = 1'b0;
    end
  endtask

  task automatic t_disabled();
    logic [7:0] last, m;
    en = 1'b0;
    cs_begin();
    header(1'b0, 1, 24'hD40024, last);
    check("R1 disabled tx idle", {24'h0, last}, 32'hFF);
    slot(8'h33, m);
    check("R1 disabled data slot", {24'h0, m}, 32'hFF);
    cs_end();
    check("R1 no upload when disabled", {31'h0, cmd_not_empty}, 0);
    check("R1 no write FIFO entry", {31'h0, wrf_empty}, 1);
    en = 1'b1;
  endtask

  task automatic t_abort();
    logic [7:0] m;
    cs_begin();
    slot(8'h83, m);
    slot(8'hD4, m);
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    check("R10 abort tx idle", {24'h0, tx_byte}, 32'hFF);
    repeat (2) @(negedge clk);
    hw_read("R10 fresh header after abort", 24'hD40019, 3, sts_reg);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b1; crb_mode = 1'b0; hw_reg_dis = 1'b0; inv_loc_en = 1'b0;
    access_regs = {8'h00, 8'h00, 8'h00, 8'h01, 8'h20};
    sts_reg = 32'h11223344; id_reg = 32'hA5B6C7D8;
    cs_n = 1'b1; byte_stb = 1'b0; rx_byte = 8'h00;
    cmd_pop = 1'b0; rdf_push = 1'b0; rdf_data = 8'h00; wrf_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hw_regs();
    t_locality();
    t_sw_modes();
    t_writes();
    t_disabled();
    t_abort();
    finish_run();
  end

endmodule